// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block runs external memory and I/O transfers for an 8-bit processor core whose low address byte and data byte share one set of pins. The core presents a request: a 16-bit address, a direction flag, a memory-or-I/O flag and, for writes, a data byte. It holds that request until the block returns a one-cycle completion pulse. Read data is returned with that pulse.

Each transfer has three phases. The first is an address phase, in which the shared lines carry the low address byte and the address latch strobe is high so that external logic can capture it. The second is a strobe phase, in which the active-low read or write strobe is asserted and the shared lines either carry write data or are released for the addressed device to drive. The strobe phase stretches for as long as the device holds its ready input low. The third is a completion phase, in which the strobes return high.

An external master can request the bus with a hold input. The block first finishes any transfer in progress. It then grants the bus on a hold-acknowledge output and turns off every output enable until the request is withdrawn. Reset turns off all the buses and drives a reset indication for attached devices.

Top module: `mbus_cycle_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after the edge that sampled it high, `reset_out` is 1, `ctrl_oe` and `ad_oe` are 0, `rd_n` and `wr_n` are 1, and `hlda` and `done` are 0. In the cycle after the first edge with `rst` low, `reset_out` is 0 and `ctrl_oe` is 1.
- R2: In the cycle after an idle edge with `req_valid` high and `hold` low, `ale` is 1, `ad_oe` is 1, `ad_out` equals `req_addr[7:0]`, `addr_hi` equals `req_addr[15:8]`, and both strobes are high.
- R3: `ale` is high for exactly one cycle per transfer and is low in every other phase.
- R4: For a read (`req_write`=0), the strobe phase has `rd_n`=0, `wr_n`=1 and `ad_oe`=0.
- R5: For a write (`req_write`=1), the strobe phase has `wr_n`=0, `rd_n`=1, `ad_oe`=1 and `ad_out` equal to `req_wdata`.
- R6: `io_m` equals `req_io` (1 = I/O, 0 = memory) in every phase of the transfer.
- R7: While `ready` is low at a strobe-phase edge, the strobe stays asserted and `done` stays low. The strobe phase ends at the first edge where `ready` is high.
- R8: `rdata` takes the value of `ad_in` at the strobe-phase edge where `ready` is high. `done` is 1 for exactly the one cycle after that edge, with both strobes high.
- R9: A `hold` raised during a transfer lets that transfer finish with its `done` pulse. `hlda` rises in the cycle after completion, and while `hlda` is 1, `ctrl_oe` and `ad_oe` are 0 and both strobes are 1.
- R10: `hold` takes priority over a pending request in idle: no `ale` appears while `hold` is high. One cycle after `hold` falls, `hlda` is 0, and the pending request then starts its address phase.
- R11: `rd_n` and `wr_n` are never both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Core transfer request, held until `done` |
| req_addr | input | 16 | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_wdata | input | 8 | Write data |
| rdata | output | 8 | Captured read data |
| done | output | 1 | One-cycle completion pulse |
| ready | input | 1 | Device ready; low inserts wait cycles |
| hold | input | 1 | External master bus request |
| hlda | output | 1 | Bus granted to external master |
| ad_in | input | 8 | Shared lines as seen by the block |
| ad_out | output | 8 | Value driven on the shared lines |
| ad_oe | output | 1 | Drive enable for the shared lines |
| addr_hi | output | 8 | Upper address byte |
| ctrl_oe | output | 1 | Drive enable for upper address and control lines |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | 1 = I/O transfer, 0 = memory transfer |
| reset_out | output | 1 | Reset indication to attached devices |

## Verification
The assertions assume that the core keeps `req_valid` and the request fields stable from the idle edge that accepts them until `done`, and that it drops `req_valid` before the idle edge that follows. The bench changes every input only on the falling clock edge. It lowers `req_valid` in the same falling-edge step where it observes `done`, so a request is never taken twice. The bench raises `hold` and `ready` at arbitrary phases, including during the strobe phase and together with a new request, because the properties place no limit on those inputs.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    localparam int MBUS_ADDR_W = 16;
    localparam int MBUS_DATA_W = 8;

    typedef enum logic [2:0] {
        ST_RESET  = 3'd0,
        ST_IDLE   = 3'd1,
        ST_ADDR   = 3'd2,
        ST_STROBE = 3'd3,
        ST_DONE   = 3'd4,
        ST_HELD   = 3'd5
    } bus_state_e;

    typedef struct packed {
        logic write;
        logic io;
    } req_kind_t;

    function automatic logic owns_bus(input bus_state_e st);
        return (st != ST_RESET) && (st != ST_HELD);
    endfunction

endpackage

// File: rtl/mbus_seq.sv
module mbus_seq
    import mbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       hold,
    input  logic       ready,
    output bus_state_e state
);

    bus_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RESET:  nxt = ST_IDLE;
            ST_IDLE:   nxt = hold ? ST_HELD : (req_valid ? ST_ADDR : ST_IDLE);
            ST_ADDR:   nxt = ST_STROBE;
            ST_STROBE: nxt = ready ? ST_DONE : ST_STROBE;
            ST_DONE:   nxt = hold ? ST_HELD : ST_IDLE;
            ST_HELD:   nxt = hold ? ST_HELD : ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RESET;
        else     state <= nxt;
    end

    // R7: a low ready keeps the strobe phase
    a_r7_wait_holds: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STROBE && !ready) |=> (state == ST_STROBE));

    // R3: the address phase always moves on after one cycle
    a_r3_addr_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ADDR) |=> (state == ST_STROBE));

    // R9: no grant while a transfer is in flight
    a_r9_finish_first: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STROBE) |=> (state != ST_HELD));

endmodule

// File: rtl/mbus_capture.sv
module mbus_capture
    import mbus_pkg::*;
#(
    parameter int ADDR_W = MBUS_ADDR_W,
    parameter int DATA_W = MBUS_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_state_e        state,
    input  logic              req_valid,
    input  logic              hold,
    input  logic              ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  req_kind_t         req_kind,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] ad_in,
    output logic [ADDR_W-1:0] lat_addr,
    output req_kind_t         lat_kind,
    output logic [DATA_W-1:0] lat_wdata,
    output logic [DATA_W-1:0] rdata
);

    logic take_req;
    logic take_data;

    assign take_req  = (state == ST_IDLE) && req_valid && !hold;
    assign take_data = (state == ST_STROBE) && ready && !lat_kind.write;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_addr  <= '0;
            lat_kind  <= '0;
            lat_wdata <= '0;
        end else if (take_req) begin
            lat_addr  <= req_addr;
            lat_kind  <= req_kind;
            lat_wdata <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            rdata <= '0;
        else if (take_data) rdata <= ad_in;
    end

    // R6: the latched request is stable through a transfer
    a_r6_kind_stable: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STROBE) |=> $stable(lat_kind));

endmodule

// File: rtl/mbus_drive.sv
module mbus_drive
    import mbus_pkg::*;
#(
    parameter int ADDR_W = MBUS_ADDR_W,
    parameter int DATA_W = MBUS_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_state_e        state,
    input  logic [ADDR_W-1:0] lat_addr,
    input  req_kind_t         lat_kind,
    input  logic [DATA_W-1:0] lat_wdata,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              ctrl_oe,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              io_m,
    output logic              hlda,
    output logic              done,
    output logic              reset_out
);

    localparam int LO_W = DATA_W;

    logic strobing;

    assign strobing  = (state == ST_STROBE);
    assign addr_hi   = lat_addr[ADDR_W-1:LO_W];
    assign ad_out    = (state == ST_ADDR) ? lat_addr[LO_W-1:0] : lat_wdata;
    assign ad_oe     = (state == ST_ADDR) || (strobing && lat_kind.write);
    assign ctrl_oe   = owns_bus(state);
    assign ale       = (state == ST_ADDR);
    assign rd_n      = !(strobing && !lat_kind.write);
    assign wr_n      = !(strobing && lat_kind.write);
    assign io_m      = lat_kind.io;
    assign hlda      = (state == ST_HELD);
    assign done      = (state == ST_DONE);
    assign reset_out = (state == ST_RESET);

    // R11
    a_r11_no_dual_strobe: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    // R9
    a_r9_grant_quiet: assert property (@(posedge clk) disable iff (rst)
        hlda |-> (rd_n && wr_n && !ctrl_oe && !ad_oe));

    // R3
    a_r3_ale_single: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);

    // R8
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4: no contention while the device drives a read
    a_r4_read_released: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe);

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        reset_out |-> (!ctrl_oe && !ad_oe && rd_n && wr_n));

endmodule

// File: rtl/mbus_cycle_ctrl.sv
module mbus_cycle_ctrl
    import mbus_pkg::*;
#(
    parameter int ADDR_W = MBUS_ADDR_W,
    parameter int DATA_W = MBUS_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_io,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              done,
    input  logic              ready,
    input  logic              hold,
    output logic              hlda,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic              ctrl_oe,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              io_m,
    output logic              reset_out
);

    bus_state_e        state;
    req_kind_t         req_kind;
    req_kind_t         lat_kind;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_wdata;

    assign req_kind.write = req_write;
    assign req_kind.io    = req_io;

    mbus_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .hold      (hold),
        .ready     (ready),
        .state     (state)
    );

    mbus_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_capture (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .req_valid (req_valid),
        .hold      (hold),
        .ready     (ready),
        .req_addr  (req_addr),
        .req_kind  (req_kind),
        .req_wdata (req_wdata),
        .ad_in     (ad_in),
        .lat_addr  (lat_addr),
        .lat_kind  (lat_kind),
        .lat_wdata (lat_wdata),
        .rdata     (rdata)
    );

    mbus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .lat_addr  (lat_addr),
        .lat_kind  (lat_kind),
        .lat_wdata (lat_wdata),
        .addr_hi   (addr_hi),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .ctrl_oe   (ctrl_oe),
        .ale       (ale),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .io_m      (io_m),
        .hlda      (hlda),
        .done      (done),
        .reset_out (reset_out)
    );

endmodule

// File: tb/mbus_cycle_ctrl_bench.sv
module mbus_cycle_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_io = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  rdata;
    logic        done;
    logic        ready = 1'b1;
    logic        hold = 1'b0;
    logic        hlda;
    logic [7:0]  ad_in = '0;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [7:0]  addr_hi;
    logic        ctrl_oe;
    logic        ale;
    logic        rd_n;
    logic        wr_n;
    logic        io_m;
    logic        reset_out;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    mbus_cycle_ctrl u_mbus_cycle_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_io(req_io), .req_wdata(req_wdata),
        .rdata(rdata), .done(done), .ready(ready), .hold(hold), .hlda(hlda),
        .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .addr_hi(addr_hi),
        .ctrl_oe(ctrl_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m),
        .reset_out(reset_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset_out", {31'd0, reset_out}, 1);
        check("R1 enables off", {30'd0, ctrl_oe, ad_oe}, 0);
        check("R1 strobes high", {30'd0, rd_n, wr_n}, 3);
        check("R1 hlda/done low", {30'd0, hlda, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset_out released", {31'd0, reset_out}, 0);
        check("R1 ctrl_oe after reset", {31'd0, ctrl_oe}, 1);
    endtask

    task automatic t_cycle(input logic wr, input logic io, input logic [15:0] a,
                           input logic [7:0] d, input int waits);
        ready     = (waits == 0);
        req_valid = 1'b1;
        req_addr  = a;
        req_write = wr;
        req_io    = io;
        req_wdata = wr ? d : 8'h00;
        ad_in     = wr ? 8'h00 : d;
        @(negedge clk);
        check("R2 ale", {31'd0, ale}, 1);
        check("R2 ad_oe", {31'd0, ad_oe}, 1);
        check("R2 low address", {24'd0, ad_out}, {24'd0, a[7:0]});
        check("R2 high address", {24'd0, addr_hi}, {24'd0, a[15:8]});
        check("R2 strobes idle", {30'd0, rd_n, wr_n}, 3);
        check("R6 io_m address", {31'd0, io_m}, {31'd0, io});
        @(negedge clk);
        check("R3 ale low in strobe", {31'd0, ale}, 0);
        check("R6 io_m strobe", {31'd0, io_m}, {31'd0, io});
        if (wr) begin
            check("R5 wr_n low", {31'd0, wr_n}, 0);
            check("R5 rd_n high", {31'd0, rd_n}, 1);
            check("R5 ad_oe", {31'd0, ad_oe}, 1);
            check("R5 write data", {24'd0, ad_out}, {24'd0, d});
        end else begin
            check("R4 rd_n low", {31'd0, rd_n}, 0);
            check("R4 wr_n high", {31'd0, wr_n}, 1);
            check("R4 released", {31'd0, ad_oe}, 0);
        end
        for (int w = 0; w < waits; w++) begin
            @(negedge clk);
            check("R7 strobe held", {30'd0, rd_n, wr_n}, wr ? 32'd2 : 32'd1);
            check("R7 no done in wait", {31'd0, done}, 0);
        end
        ready = 1'b1;
        @(negedge clk);
        check("R8 done", {31'd0, done}, 1);
        check("R8 strobes high at done", {30'd0, rd_n, wr_n}, 3);
        check("R3 ale low at done", {31'd0, ale}, 0);
        if (!wr) check("R8 rdata", {24'd0, rdata}, {24'd0, d});
        req_valid = 1'b0;
        ad_in = 8'hEE;
        @(negedge clk);
        check("R8 done one cycle", {31'd0, done}, 0);
        check("R3 no second ale", {31'd0, ale}, 0);
        if (!wr) check("R8 rdata kept", {24'd0, rdata}, {24'd0, d});
    endtask

    task automatic t_hold_mid();
        ready = 1'b0; req_valid = 1'b1; req_addr = 16'h4321;
        req_write = 1'b0; req_io = 1'b0; ad_in = 8'h77;
        @(negedge clk);
        @(negedge clk);
        hold = 1'b1;
        @(negedge clk);
        check("R9 cycle continues under hold", {31'd0, rd_n}, 0);
        check("R9 no grant mid-cycle", {31'd0, hlda}, 0);
        ready = 1'b1;
        @(negedge clk);
        check("R9 done before grant", {31'd0, done}, 1);
        check("R9 hlda not yet", {31'd0, hlda}, 0);
        check("R9 rdata", {24'd0, rdata}, 32'h77);
        req_valid = 1'b0;
        @(negedge clk);
        check("R9 hlda granted", {31'd0, hlda}, 1);
        check("R9 outputs off", {30'd0, ctrl_oe, ad_oe}, 0);
        check("R9 strobes high", {30'd0, rd_n, wr_n}, 3);
        hold = 1'b0;
        @(negedge clk);
        check("R9 hlda released", {31'd0, hlda}, 0);
        check("R9 ctrl_oe back", {31'd0, ctrl_oe}, 1);
    endtask

    task automatic t_hold_priority();
        hold = 1'b1; req_valid = 1'b1; req_addr = 16'h9A5C;
        req_write = 1'b1; req_io = 1'b1; req_wdata = 8'h3C; ready = 1'b1;
        @(negedge clk);
        check("R10 hlda first", {31'd0, hlda}, 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R10 no ale under hold", {31'd0, ale}, 0);
        end
        hold = 1'b0;
        @(negedge clk);
        check("R10 hlda low", {31'd0, hlda}, 0);
        check("R10 not started yet", {31'd0, ale}, 0);
        @(negedge clk);
        check("R10 request starts", {31'd0, ale}, 1);
        check("R10 address", {24'd0, ad_out}, 32'h5C);
        @(negedge clk);
        check("R10 write strobe", {31'd0, wr_n}, 0);
        check("R6 io_m I/O write", {31'd0, io_m}, 1);
        @(negedge clk);
        check("R10 done", {31'd0, done}, 1);
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_cycle(1'b0, 1'b0, 16'h12A5, 8'h5A, 0);
        t_cycle(1'b0, 1'b1, 16'hFF00, 8'hC3, 3);
        t_cycle(1'b1, 1'b0, 16'h00FF, 8'h81, 0);
        t_cycle(1'b1, 1'b1, 16'h8001, 8'h00, 2);
        t_hold_mid();
        t_hold_priority();
        t_reset();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule